// File: doc/BRIEF.md
# In-Order Retirement Buffer with Tag Release

This block keeps a circular record of instructions in the order they were dispatched, and it retires them strictly in that order. At dispatch, each entry captures three things: the physical tag that was newly given to the instruction's destination, the physical tag that this destination displaced, and whether the instruction writes a register at all. The execution units later mark an entry as finished by giving its index. The entry at the head leaves only once it is finished. When it leaves, the displaced tag goes back to the free list of the rename logic.

The dispatch stage reads the index it is about to fill on `allocIdx`, and it must hold back while `robFull` is high. At most one entry retires in each cycle. Its release strobe and tag appear on the retire outputs during the cycle in which the head pointer moves. A flush empties the whole buffer in one cycle.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `robFull`=0, `allocIdx`=0, and `retValid`, `retFreeValid` are 0 with `retFreeTag`=`retDestTag`=0.
- R2: A dispatch with `dispValid`=1 while `robFull`=0 and `flush`=0 fills entry `allocIdx`, and `allocIdx` then steps by one, wrapping from DEPTH-1 to 0.
- R3: After DEPTH dispatches without retirement, `robFull`=1. While it is high, a dispatch is refused and leaves `allocIdx` and the stored entries unchanged.
- R4: `retValid` is 1 only when the head entry is allocated and has been marked complete. The head then advances by one, so at most one entry retires per cycle.
- R5: A younger entry that completes before the head stays in the buffer (no `retValid`) until every older entry has retired, and retirements come out in dispatch order.
- R6: When the retiring entry has a destination, `retFreeValid`=1 and `retFreeTag` carries its displaced (old) tag, not its own. `retDestTag` shows its own new tag for information.
- R7: When the retiring entry has no destination (`dispHasDest`=0 at dispatch), `retValid`=1 with `retFreeValid`=0, `retFreeTag`=0 and `retDestTag`=0.
- R8: Dispatch and retirement may occur in the same cycle. Occupancy is then unchanged.
- R9: `flush`=1 suppresses retirement and dispatch in that cycle. The next cycle shows an empty buffer with `allocIdx`=0 and `robFull`=0.
- R10: A completion marker for an index that holds no allocated entry has no effect. An entry dispatched there later still waits for its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispHasDest | input | 1 | Dispatched instruction writes a register |
| dispNewTag | input | TAG_W | Newly assigned physical tag |
| dispOldTag | input | TAG_W | Physical tag displaced by this dispatch |
| cmplValid | input | 1 | Completion marker strobe |
| cmplIdx | input | IDX_W | Entry index being marked complete |
| flush | input | 1 | Empty the buffer |
| allocIdx | output | IDX_W | Index the next dispatch will fill |
| robFull | output | 1 | No free entry; dispatch refused |
| retValid | output | 1 | Head entry retires this cycle |
| retFreeValid | output | 1 | Retiring entry releases a tag |
| retFreeTag | output | TAG_W | Old tag returned to the free list |
| retDestTag | output | TAG_W | Retiring entry's own destination tag |

## Verification
The bench completes younger entries before the head. A design that does not keep program order would retire them early, or would release tags in the wrong order. It completes an index that is empty at the time and later refills it. A design that keeps stale completion bits would retire the new entry before it has finished. It also dispatches while the buffer is full and while a retirement happens. A design with wrong wrap-bit handling would overwrite live entries or report a full buffer as empty. Finally, it flushes while the head is ready to retire. A design that does not gate retirement would release a tag that belongs to squashed state.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic allocEn;
    logic retireEn;
    logic flushEn;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic             flush,
  input  logic             headReady,
  output robStrobe_t       strb,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [PTR_W-1:0] occupancy;

  assign headIdx   = headPtr[IDX_W-1:0];
  assign tailIdx   = tailPtr[IDX_W-1:0];
  assign empty     = (headPtr == tailPtr);
  assign full      = (headIdx == tailIdx) && (headPtr[IDX_W] != tailPtr[IDX_W]);
  assign occupancy = tailPtr - headPtr;

  always_comb begin
    strb.flushEn  = flush;
    strb.allocEn  = dispValid && !full && !flush;
    strb.retireEn = headReady && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strb.allocEn)  tailPtr <= tailPtr + PTR_W'(1);
      if (strb.retireEn) headPtr <= headPtr + PTR_W'(1);
    end
  end

  // R2: accepted dispatch moves the tail by exactly one slot
  assert_alloc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> tailIdx == IDX_W'($past(tailIdx) + IDX_W'(1)));

  // R3: a full buffer refuses dispatch
  assert_full_refuse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (full && dispValid && !flush) |=> $stable(tailIdx));

  // R8: simultaneous dispatch and retire keeps occupancy
  assert_pair_keeps_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.allocEn && strb.retireEn) |=> occupancy == $past(occupancy));

  // R9: flush empties in one cycle
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (empty && tailIdx == '0));

  // R4: never more entries than slots
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= PTR_W'(DEPTH));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  robStrobe_t       strb,
  input  logic [IDX_W-1:0] headIdx,
  input  logic [IDX_W-1:0] tailIdx,
  input  logic             dispHasDest,
  input  logic [TAG_W-1:0] dispNewTag,
  input  logic [TAG_W-1:0] dispOldTag,
  input  logic             cmplValid,
  input  logic [IDX_W-1:0] cmplIdx,
  output logic             headReady,
  output logic             headHasDest,
  output logic [TAG_W-1:0] headNewTag,
  output logic [TAG_W-1:0] headOldTag
);
  logic [DEPTH-1:0] entValid, entDone, entHasDest;
  logic [TAG_W-1:0] entNewTag [DEPTH];
  logic [TAG_W-1:0] entOldTag [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic isTail, isHead, isCmpl;
    assign isTail = strb.allocEn  && (tailIdx == IDX_W'(i));
    assign isHead = strb.retireEn && (headIdx == IDX_W'(i));
    assign isCmpl = cmplValid && (cmplIdx == IDX_W'(i)) && entValid[i];

    always_ff @(posedge clk) begin
      if (!rstN || strb.flushEn) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
      end else if (isTail) begin
        entValid[i] <= 1'b1;
        entDone[i]  <= 1'b0;
      end else if (isHead) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
      end else if (isCmpl) begin
        entDone[i]  <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entHasDest[i] <= 1'b0;
        entNewTag[i]  <= '0;
        entOldTag[i]  <= '0;
      end else if (isTail) begin
        entHasDest[i] <= dispHasDest;
        entNewTag[i]  <= dispHasDest ? dispNewTag : '0;
        entOldTag[i]  <= dispHasDest ? dispOldTag : '0;
      end
    end
  end

  assign headReady   = entValid[headIdx] && entDone[headIdx];
  assign headHasDest = entHasDest[headIdx];
  assign headNewTag  = entNewTag[headIdx];
  assign headOldTag  = entOldTag[headIdx];

  // R4: a retired slot is vacated on the next cycle
  assert_retire_vacates_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.retireEn && !strb.allocEn) |=> !entValid[$past(headIdx)]);

  // R10: a slot never becomes done while unallocated
  assert_done_implies_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((entDone & ~entValid) == '0));
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic             dispHasDest,
  input  logic [TAG_W-1:0] dispNewTag,
  input  logic [TAG_W-1:0] dispOldTag,
  input  logic             cmplValid,
  input  logic [IDX_W-1:0] cmplIdx,
  input  logic             flush,
  output logic [IDX_W-1:0] allocIdx,
  output logic             robFull,
  output logic             retValid,
  output logic             retFreeValid,
  output logic [TAG_W-1:0] retFreeTag,
  output logic [TAG_W-1:0] retDestTag
);
  robStrobe_t       strb;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic             headReady, headHasDest, empty;
  logic [TAG_W-1:0] headNewTag, headOldTag;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .flush(flush),
    .headReady(headReady), .strb(strb), .headIdx(headIdx),
    .tailIdx(tailIdx), .full(robFull), .empty(empty)
  );

  rob_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .headIdx(headIdx),
    .tailIdx(tailIdx), .dispHasDest(dispHasDest), .dispNewTag(dispNewTag),
    .dispOldTag(dispOldTag), .cmplValid(cmplValid), .cmplIdx(cmplIdx),
    .headReady(headReady), .headHasDest(headHasDest),
    .headNewTag(headNewTag), .headOldTag(headOldTag)
  );

  assign allocIdx     = tailIdx;
  assign retValid     = strb.retireEn;
  assign retFreeValid = strb.retireEn && headHasDest;
  assign retFreeTag   = retFreeValid ? headOldTag : '0;
  assign retDestTag   = retFreeValid ? headNewTag : '0;

  // R7: nothing is released for a destination-less retirement
  assert_nodest_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !retFreeValid |-> (retFreeTag == '0 && retDestTag == '0));

  // R4: an empty buffer never retires
  assert_empty_no_retire_R4: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !retValid);
endmodule

// File: tb/sim_rob_top.sv
module sim_rob_top;
  localparam int DEPTH = 4;
  localparam int TAG_W = 6;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0, dispHasDest = 1'b0, cmplValid = 1'b0, flush = 1'b0;
  logic [TAG_W-1:0] dispNewTag = '0, dispOldTag = '0;
  logic [IDX_W-1:0] cmplIdx = '0;
  logic [IDX_W-1:0] allocIdx;
  logic robFull, retValid, retFreeValid;
  logic [TAG_W-1:0] retFreeTag, retDestTag;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  rob_top #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispHasDest(dispHasDest),
    .dispNewTag(dispNewTag), .dispOldTag(dispOldTag), .cmplValid(cmplValid),
    .cmplIdx(cmplIdx), .flush(flush), .allocIdx(allocIdx), .robFull(robFull),
    .retValid(retValid), .retFreeValid(retFreeValid), .retFreeTag(retFreeTag),
    .retDestTag(retDestTag)
  );

  typedef struct packed {
    logic             disp;
    logic             hd;
    logic [TAG_W-1:0] nt;
    logic [TAG_W-1:0] ot;
    logic             cv;
    logic [IDX_W-1:0] ci;
    logic             fl;
    logic             eRet;
    logic             eFree;
    logic [TAG_W-1:0] eTag;
    logic [TAG_W-1:0] eDst;
    logic [IDX_W-1:0] eIdx;
    logic             eFull;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t TBL [NVEC] = '{
    '{1,1,10,1, 0,0,0, 0,0,0,0, 0,0},  // R2 first dispatch
    '{1,0, 0,0, 0,0,0, 0,0,0,0, 1,0},  // store, no dest
    '{1,1,11,2, 1,1,0, 0,0,0,0, 2,0},  // younger completes (R5)
    '{1,1,12,3, 1,2,0, 0,0,0,0, 3,0},  // R5 head not done
    '{1,1,13,4, 0,0,0, 0,0,0,0, 0,1},  // R3 refused while full
    '{0,0, 0,0, 1,0,0, 0,0,0,0, 0,1},  // complete head
    '{0,0, 0,0, 0,0,0, 1,1,1,10,0,1},  // R6 retire frees old tag
    '{1,1,14,5, 0,0,0, 1,0,0,0, 0,0},  // R7/R8 nodest retire + alloc
    '{0,0, 0,0, 0,0,0, 1,1,2,11,1,0},  // R5 in order
    '{0,0, 0,0, 1,3,0, 0,0,0,0, 1,0},
    '{0,0, 0,0, 0,0,0, 1,1,3,12,1,0},
    '{0,0, 0,0, 1,2,0, 0,0,0,0, 1,0},  // R10 stale completion
    '{1,1,15,6, 0,0,0, 0,0,0,0, 1,0},
    '{1,1,16,7, 0,0,0, 0,0,0,0, 2,0},  // refill stale slot
    '{0,0, 0,0, 1,0,0, 0,0,0,0, 3,0},
    '{0,0, 0,0, 0,0,0, 1,1,5,14,3,0},
    '{0,0, 0,0, 1,1,0, 0,0,0,0, 3,0},
    '{0,0, 0,0, 0,0,0, 1,1,6,15,3,0},
    '{0,0, 0,0, 1,2,0, 0,0,0,0, 3,0},  // R10 head not retired early
    '{0,0, 0,0, 0,0,1, 0,0,0,0, 3,0},  // R9 flush gates retire
    '{0,0, 0,0, 0,0,0, 0,0,0,0, 0,0}   // R9 empty after flush
  };

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idleIn();
    dispValid = 0; dispHasDest = 0; dispNewTag = '0; dispOldTag = '0;
    cmplValid = 0; cmplIdx = '0; flush = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    idleIn();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : stim
    doReset();
    // R1 reset state
    check("R1 full", int'(robFull), 0);
    check("R1 allocIdx", int'(allocIdx), 0);
    check("R1 retValid", int'(retValid), 0);
    check("R1 retFreeValid", int'(retFreeValid), 0);
    check("R1 retFreeTag", int'(retFreeTag), 0);

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      dispValid = TBL[k].disp; dispHasDest = TBL[k].hd;
      dispNewTag = TBL[k].nt; dispOldTag = TBL[k].ot;
      cmplValid = TBL[k].cv; cmplIdx = TBL[k].ci; flush = TBL[k].fl;
      #1;
      check($sformatf("R4 retValid row%0d", k), int'(retValid), int'(TBL[k].eRet));
      check($sformatf("R6 retFreeValid row%0d", k), int'(retFreeValid), int'(TBL[k].eFree));
      check($sformatf("R6 retFreeTag row%0d", k), int'(retFreeTag), int'(TBL[k].eTag));
      check($sformatf("R7 retDestTag row%0d", k), int'(retDestTag), int'(TBL[k].eDst));
      check($sformatf("R2 allocIdx row%0d", k), int'(allocIdx), int'(TBL[k].eIdx));
      check($sformatf("R3 robFull row%0d", k), int'(robFull), int'(TBL[k].eFull));
    end

    // R3 / R5 directed: fill, refuse, complete in reverse, drain in order
    doReset();
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      dispValid = 1; dispHasDest = 1;
      dispNewTag = TAG_W'(20 + k); dispOldTag = TAG_W'(40 + k);
    end
    @(negedge clk);
    dispValid = 1; dispNewTag = TAG_W'(63); dispOldTag = TAG_W'(63);
    #1;
    check("R3 full after DEPTH", int'(robFull), 1);
    check("R3 allocIdx wrapped", int'(allocIdx), 0);
    for (int k = DEPTH - 1; k >= 0; k--) begin
      @(negedge clk);
      dispValid = 0; cmplValid = 1; cmplIdx = IDX_W'(k);
      #1;
      check("R5 no early retire", int'(retValid), 0);
    end
    @(negedge clk);
    idleIn();
    for (int k = 0; k < DEPTH; k++) begin
      #1;
      check("R5 drain retValid", int'(retValid), 1);
      check("R5 drain order", int'(retFreeTag), 40 + k);
      @(negedge clk);
    end
    #1;
    check("R4 drained no retire", int'(retValid), 0);
    check("R3 drained not full", int'(robFull), 0);

    // R9: dispatch during flush is ignored
    @(negedge clk);
    dispValid = 1; dispHasDest = 1; flush = 1;
    @(negedge clk);
    idleIn();
    #1;
    check("R9 dispatch ignored", int'(allocIdx), 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule